// File: doc/BRIEF.md
# Random-Access Scan State Array

This block is a bank of state flip-flops built for random-access test. Test access does not use a shift chain. Each flip-flop is reached through a decoded address, so it can be written or read on its own. A small address register is loaded one bit at a time from a serial address pin, and it advances only on cycles where the address clock enable is high. A one-hot decoder turns the stored address into per-cell select lines.

In functional mode (test control low) every cell captures its functional data input on each system clock. In test mode (test control high) only the addressed cell loads the serial scan input, and every other cell keeps its value. The addressed cell's value is always visible on the single scan output. A tester can therefore flip exactly one state bit between two clocks, which is what single-input-change delay patterns need. It can also read any bit without disturbing the rest of the state.

Top module: `ras_array`

## Requirements
- R1: A synchronous active-high reset clears every state bit and the address register to zero. After reset, the scan output therefore reads cell 0, which is 0.
- R2: With test control low, on each clock every state output takes the value its functional data input had before that edge.
- R3: The address register is ADDR_W = ceil(log2(N_FF)) bits wide. On a clock with the address enable high, it shifts left by one and takes the serial address bit into bit 0. An address is therefore entered most significant bit first.
- R4: With test control high and an address below N_FF, the addressed cell loads the scan input and all other cells hold their values. At most one state bit changes per clock.
- R5: The scan output equals the current value of the cell selected by the current address register contents. It updates in the same cycle that either of them changes.
- R6: An address at or above N_FF selects no cell. In test mode no state bit changes, and the scan output reads 0.
- R7: With test control high, the functional data inputs have no effect on the state.
- R8: On a clock with the address enable low, the address register keeps its value, so the scan output keeps reading the same cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the address register also advances on it when enabled |
| rst | input | 1 | Synchronous reset, active high |
| func_d | input | N_FF | Functional data inputs, one per cell |
| state_q | output | N_FF | Registered state outputs |
| test_en | input | 1 | Test control: 1 = addressed write, 0 = functional capture |
| scan_in | input | 1 | Serial data written into the addressed cell in test mode |
| scan_out | output | 1 | Value of the addressed cell, 0 when the address is out of range |
| addr_si | input | 1 | Serial address bit, most significant bit first |
| addr_ce | input | 1 | Address register shift enable |

## Verification
The assertions assume that all inputs are stable around each rising clock edge. They judge a test-mode write against the address that was held before the edge, even when the address register shifts on that same edge. The stimulus drives every input on the falling edge. It also includes cycles where address shifting and test writes coincide, so the same-edge ordering is exercised rather than avoided. The addresses written include both ends of the valid range and values between N_FF and the largest encodable address.

// File: rtl/ras_pkg.sv
package ras_pkg;
  // Width of an address able to name n cells; never below one bit.
  function automatic int addr_width(input int n);
    if (n <= 2) return 1;
    return $clog2(n);
  endfunction
endpackage

// File: rtl/ras_addr_sr.sv
module ras_addr_sr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic         si,
  output logic [W-1:0] addr
);
  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)     addr <= '0;
        else if (ce) addr <= si;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)     addr <= '0;
        else if (ce) addr <= {addr[W-2:0], si};
      end
    end
  endgenerate

  // R3
  shift_in_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && ce) |=> (addr[0] == $past(si)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !ce) |=> $stable(addr));
endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
  parameter int N = 12,
  parameter int W = 4
) (
  input  logic [W-1:0] addr,
  output logic [N-1:0] sel
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_dec
      assign sel[i] = (addr == W'(i));
    end
  endgenerate
endmodule

// File: rtl/ras_cell_bank.sv
module ras_cell_bank #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_en,
  input  logic         scan_in,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] func_d,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_cell
      always_ff @(posedge clk) begin
        if (rst)           q[i] <= 1'b0;
        else if (!test_en) q[i] <= func_d[i];
        else if (sel[i])   q[i] <= scan_in;
      end
    end
  endgenerate

  // R4
  single_change_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && test_en) |=> ($countones(q ^ $past(q)) <= 1));
endmodule

// File: rtl/ras_array.sv
module ras_array #(
  parameter int N_FF = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_FF-1:0] func_d,
  output logic [N_FF-1:0] state_q,
  input  logic            test_en,
  input  logic            scan_in,
  output logic            scan_out,
  input  logic            addr_si,
  input  logic            addr_ce
);
  localparam int ADDR_W = ras_pkg::addr_width(N_FF);

  logic [ADDR_W-1:0] addr_q;
  logic [N_FF-1:0]   sel;

  ras_addr_sr #(.W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .ce(addr_ce), .si(addr_si), .addr(addr_q)
  );

  ras_decoder #(.N(N_FF), .W(ADDR_W)) u_dec (
    .addr(addr_q), .sel(sel)
  );

  ras_cell_bank #(.N(N_FF)) u_bank (
    .clk(clk), .rst(rst), .test_en(test_en), .scan_in(scan_in),
    .sel(sel), .func_d(func_d), .q(state_q)
  );

  assign scan_out = |(state_q & sel);

  // R2
  func_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !test_en) |=> (state_q == $past(func_d)));

  // R4
  addressed_write_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && test_en && (int'(addr_q) < N_FF))
      |=> (state_q[$past(addr_q)] == $past(scan_in)));

  // R6
  out_of_range_read_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(addr_q) >= N_FF) |-> (scan_out == 1'b0));

  // R6
  out_of_range_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && test_en && (int'(addr_q) >= N_FF)) |=> $stable(state_q));
endmodule

// File: tb/ras_array_tb.sv
module ras_array_tb;
  localparam int N = 12;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] func_d = '0;
  logic [N-1:0] state_q;
  logic test_en = 1'b0, scan_in = 1'b0, scan_out;
  logic addr_si = 1'b0, addr_ce = 1'b0;

  always #2.5 clk = ~clk;

  ras_array #(.N_FF(N)) u_dut (
    .clk(clk), .rst(rst), .func_d(func_d), .state_q(state_q),
    .test_en(test_en), .scan_in(scan_in), .scan_out(scan_out),
    .addr_si(addr_si), .addr_ce(addr_ce)
  );

  logic [N-1:0] exp_q_q[$];
  logic         exp_so_q[$];
  string        tag_q[$];
  int checks = 0, fails = 0;
  logic [N-1:0] m_q = '0;
  logic [W-1:0] m_a = '0;
  bit done = 0;

  // Driver: drive at falling edge, push what the next rising edge must give.
  task automatic step(input logic r, input logic te, input logic si,
                      input logic [N-1:0] d, input logic ce, input logic asi,
                      input string tag);
    @(negedge clk);
    rst = r; test_en = te; scan_in = si; func_d = d;
    addr_ce = ce; addr_si = asi;
    if (r) begin
      m_q = '0; m_a = '0;
    end else begin
      if (!te) m_q = d;
      else if (int'(m_a) < N) m_q[m_a] = si;
      if (ce) m_a = {m_a[W-2:0], asi};
    end
    exp_q_q.push_back(m_q);
    exp_so_q.push_back((int'(m_a) < N) ? m_q[m_a] : 1'b0);
    tag_q.push_back(tag);
  endtask

  // R3: enter an address most significant bit first, in functional mode.
  task automatic load_addr(input logic [W-1:0] a, input logic [N-1:0] d);
    for (int i = W - 1; i >= 0; i--) step(0, 0, 0, d, 1, a[i], "R3");
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (exp_q_q.size() > 0) begin
      logic [N-1:0] eq;
      logic es;
      string t;
      eq = exp_q_q.pop_front();
      es = exp_so_q.pop_front();
      t  = tag_q.pop_front();
      checks++;
      if (state_q !== eq || scan_out !== es) begin
        fails++;
        $display("FAIL %s: state_q=%h scan_out=%b expected state_q=%h scan_out=%b",
                 t, state_q, scan_out, eq, es);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(1, 0, 0, 12'hFFF, 0, 0, "R1");
    step(1, 1, 1, 12'hFFF, 1, 1, "R1");
    // R2: functional capture under several patterns
    step(0, 0, 0, 12'hA5A, 0, 0, "R2");
    step(0, 0, 0, 12'h3C3, 0, 0, "R2");
    step(0, 0, 0, 12'hFFF, 0, 0, "R2");
    step(0, 0, 0, 12'h000, 0, 0, "R2");
    load_addr(4'd5, 12'h000);
    // R8: enable low keeps the address, scan_out keeps reading cell 5
    step(0, 0, 0, 12'h020, 0, 1, "R8");
    step(0, 0, 0, 12'h000, 0, 1, "R8");
    // R4/R5/R7: addressed writes, func_d deliberately hostile
    step(0, 1, 1, 12'hFFF, 0, 0, "R4");
    step(0, 1, 1, 12'h000, 0, 0, "R7");
    step(0, 1, 0, 12'hFDF, 0, 0, "R5");
    step(0, 1, 1, 12'h555, 0, 0, "R4");
    // Boundary cells 0 and N-1
    load_addr(4'd0, 12'h0F0);
    step(0, 1, 0, 12'hFFF, 0, 0, "R4");
    step(0, 1, 1, 12'h000, 0, 0, "R5");
    load_addr(4'd11, 12'h00F);
    step(0, 1, 0, 12'hFFF, 0, 0, "R4");
    step(0, 1, 1, 12'h000, 0, 0, "R5");
    // R6: out-of-range addresses 12 and 15
    load_addr(4'd12, 12'hFFF);
    step(0, 1, 0, 12'h000, 0, 0, "R6");
    step(0, 1, 1, 12'h123, 0, 0, "R6");
    load_addr(4'd15, 12'h000);
    step(0, 1, 1, 12'hFFF, 0, 0, "R6");
    // Address shifting during test writes: write uses pre-edge address
    for (int i = 0; i < 8; i++) step(0, 1, i[0], 12'hAAA, 1, i[1], "R4");
    step(0, 1, 1, 12'h000, 0, 0, "R5");
    step(1, 0, 0, 12'h000, 0, 0, "R1");
    step(0, 0, 0, 12'h000, 0, 0, "R1");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule